// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block watches the write cycles that a host issues to a parallel NOR flash and recognises the multi-write command protocol those parts use. A command is only accepted after an unlock handshake of two fixed data patterns written to two fixed addresses. Once the command byte arrives, the block turns it into a single-cycle command pulse (program, chip erase, sector erase, erase suspend, erase resume, identification entry, query entry or reset) for the erase/program timing engine and the storage array that sit beside it. It also reports its current mode and write-cycle position.

The byte address used for matching is first divided by the bus width (8, 16 or 32 bits), and only its low 11 bits are compared with the two unlock addresses, which are parameters. A fast path keeps the decoder at the command cycle so that repeated programs need no unlock handshake. The timing engine feeds back four signals: erase completion, whether the sector-erase accumulation window is still open, whether an erase is held in suspension, and whether the current write address falls in a suspended sector.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The write-cycle output `cycle` is 0 when idle. Data 0xAA at unlock address 0 moves it to 1, then data 0x55 at unlock address 1 moves it to 2. Any other write at cycle 1 returns to cycle 0 and pulses `cmd_reset`. `cycle` never exceeds 8.
- R2: The compared address is `wr_addr` shifted right by 0, 1 or 2 for `bus_width` 0, 1 or 2 (3 acts as 2), truncated to its low 11 bits.
- R3: At cycle 2 the command byte must be written at unlock address 0. 0x90 sets `mode` 1 (identification), goes to cycle 3 and pulses `cmd_ident`. 0xA0 sets `mode` 3 (program). 0x80 sets `mode` 4 (erase setup). Any other byte resets. Mode codes: 0 read, 1 identification, 2 query, 3 program, 4 erase setup, 5 chip erase, 6 sector erase.
- R4: The write after 0xA0 is the program data cycle. It pulses `cmd_program`, with that write's address on `cmd_addr` and its data on `cmd_data`, and returns to cycle 0 (or to cycle 2 on the fast path). 0xF0 is data there. When `erase_held` and `target_held` are both high, no pulse is given.
- R5: Command byte 0x20 sets `fast_path`, and the decoder stays at cycle 2 with the address check skipped. Data 0x00 in identification mode while `fast_path` is set clears it and resets.
- R6: After 0x80, a second 0xAA/0x55 handshake must follow. Then 0x10 at unlock address 0 pulses `cmd_chip_erase` (mode 5, cycle 6), and 0x30 at any address pulses `cmd_sector_erase` (mode 6, cycle 6). Both are refused with a reset while `erase_held` is high.
- R7: Data 0x98 at compared address 0x55 enters mode 2 with `pulses cmd_query`. From idle this goes to cycle 7. From identification mode it goes to cycle 8, where 0xF0 returns to mode 1, cycle 3. Any other write in query mode resets to idle.
- R8: Data 0xF0 resets to idle, except in chip erase, in sector erase and at the program data cycle.
- R9: At cycle 0, 0x30 pulses `cmd_resume` and enters mode 6, cycle 6 if `erase_held` is high, and resets otherwise. 0xB0 at cycle 0 changes nothing.
- R10: In sector erase, 0xB0 pulses `cmd_suspend` and returns to idle. While `sector_window_open` is high, 0x30 pulses another `cmd_sector_erase` and other data resets. Once the window has closed, other writes are ignored. Chip erase ignores all writes.
- R11: `erase_finished` in mode 5 or 6 returns to mode 0, at cycle 0 (cycle 2 when `fast_path` is set). A write in the same cycle is decoded from that returned state.
- R12: A synchronous `rst` clears the cycle, mode, fast path and all pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Low byte of the write data |
| bus_width | input | 2 | 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit bus |
| erase_finished | input | 1 | Erase completion pulse from the timing engine |
| sector_window_open | input | 1 | Further sector-erase commands still accepted |
| erase_held | input | 1 | An erase is suspended |
| target_held | input | 1 | The write address lies in a suspended sector |
| cycle | output | 4 | Write-cycle position 0..8 |
| mode | output | 3 | Current mode code (see R3) |
| fast_path | output | 1 | Unlock-free command mode active |
| cmd_program | output | 1 | Program pulse |
| cmd_chip_erase | output | 1 | Chip erase pulse |
| cmd_sector_erase | output | 1 | Sector erase pulse |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_resume | output | 1 | Erase resume pulse |
| cmd_ident | output | 1 | Identification entry pulse |
| cmd_query | output | 1 | Query entry pulse |
| cmd_reset | output | 1 | Sequence reset pulse |
| cmd_addr | output | ADDR_W | Address of the last write |
| cmd_data | output | 8 | Data of the last write |

## Verification
The collision of interest is an erase completion from the timing engine arriving in the same cycle as a host write. The bench raises `erase_finished` together with an unlock write, both during a normal sector erase and during one started from the fast path. It expects the write to be decoded against the post-completion state: cycle 1 in the first case, and the fast-path command cycle in the second. A behavioural model, updated on every edge, is compared with cycle, mode, fast path and the pulse set on every clock, so any other overlap between feedback inputs and writes is judged as well.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        MODE_READ        = 3'd0,
        MODE_AUTOSEL     = 3'd1,
        MODE_QUERY       = 3'd2,
        MODE_PROGRAM     = 3'd3,
        MODE_ERASE_SETUP = 3'd4,
        MODE_CHIP        = 3'd5,
        MODE_SECTOR      = 3'd6
    } mode_e;

    localparam int NUM_PULSE = 8;
    localparam int P_PROG    = 7;
    localparam int P_CHIP    = 6;
    localparam int P_SECT    = 5;
    localparam int P_SUSP    = 4;
    localparam int P_RESUME  = 3;
    localparam int P_IDENT   = 2;
    localparam int P_QUERY   = 1;
    localparam int P_RESET   = 0;

    localparam logic [3:0] CYC_IDLE  = 4'd0;
    localparam logic [3:0] CYC_UNL_B = 4'd1;
    localparam logic [3:0] CYC_CMD   = 4'd2;
    localparam logic [3:0] CYC_ARG   = 4'd3;
    localparam logic [3:0] CYC_UNL_C = 4'd4;
    localparam logic [3:0] CYC_UNL_D = 4'd5;
    localparam logic [3:0] CYC_BUSY  = 4'd6;
    localparam logic [3:0] CYC_QRY   = 4'd7;
    localparam logic [3:0] CYC_AQRY  = 4'd8;

    localparam logic [7:0] D_KEY_A   = 8'hAA;
    localparam logic [7:0] D_KEY_B   = 8'h55;
    localparam logic [7:0] D_BYPASS  = 8'h20;
    localparam logic [7:0] D_ERASE   = 8'h80;
    localparam logic [7:0] D_IDENT   = 8'h90;
    localparam logic [7:0] D_PROG    = 8'hA0;
    localparam logic [7:0] D_CHIP    = 8'h10;
    localparam logic [7:0] D_SECT    = 8'h30;
    localparam logic [7:0] D_SUSP    = 8'hB0;
    localparam logic [7:0] D_QUERY   = 8'h98;
    localparam logic [7:0] D_RESET   = 8'hF0;
    localparam logic [7:0] D_EXIT    = 8'h00;

    typedef struct packed {
        logic [3:0]           cyc;
        mode_e                mode;
        logic                 bypass;
        logic [NUM_PULSE-1:0] pulse;
    } seq_t;

endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
    parameter int          ADDR_W    = 24,
    parameter int          CMP_W     = 11,
    parameter logic [10:0] UNLOCK0   = 11'h555,
    parameter logic [10:0] UNLOCK1   = 11'h2AA,
    parameter logic [10:0] QUERY_OFS = 11'h055
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        bus_width,
    output logic              hit_u0,
    output logic              hit_u1,
    output logic              hit_qry
);
    localparam int NUM_W = 3;

    logic [CMP_W-1:0] cand [NUM_W];
    logic [CMP_W-1:0] scaled;

    for (genvar k = 0; k < NUM_W; k++) begin : g_width
        assign cand[k] = CMP_W'(wr_addr >> k);
    end

    always_comb begin
        unique case (bus_width)
            2'd0:    scaled = cand[0];
            2'd1:    scaled = cand[1];
            default: scaled = cand[2];
        endcase
    end

    assign hit_u0  = (scaled == CMP_W'(UNLOCK0));
    assign hit_u1  = (scaled == CMP_W'(UNLOCK1));
    assign hit_qry = (scaled == CMP_W'(QUERY_OFS));
endmodule

// File: rtl/fcd_seq_core.sv
module fcd_seq_core
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    input  logic                 hit_u0,
    input  logic                 hit_u1,
    input  logic                 hit_qry,
    input  logic                 erase_finished,
    input  logic                 sector_window_open,
    input  logic                 erase_held,
    input  logic                 target_held,
    output logic [3:0]           cyc_o,
    output mode_e                mode_o,
    output logic                 bypass_o,
    output logic [NUM_PULSE-1:0] pulse_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [7:0]           data_o
);
    seq_t              st_d, st_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [7:0]        data_d, data_q;

    function automatic seq_t go_reset(input seq_t s);
        seq_t r = s;
        r.cyc           = CYC_IDLE;
        r.mode          = MODE_READ;
        r.bypass        = 1'b0;
        r.pulse[P_RESET] = 1'b1;
        return r;
    endfunction

    function automatic seq_t go_rest(input seq_t s);
        seq_t r = s;
        r.cyc  = s.bypass ? CYC_CMD : CYC_IDLE;
        r.mode = MODE_READ;
        return r;
    endfunction

    // Decode of a write that opens a sequence (idle, or first write of the second handshake)
    function automatic seq_t open_write(input seq_t s, input logic [7:0] d,
                                        input logic u0, input logic qy,
                                        input logic held);
        seq_t r = s;
        if (qy && d == D_QUERY) begin
            r.cyc           = CYC_QRY;
            r.mode          = MODE_QUERY;
            r.pulse[P_QUERY] = 1'b1;
        end else if (d == D_SECT) begin
            if (held) begin
                r.cyc            = CYC_BUSY;
                r.mode           = MODE_SECTOR;
                r.pulse[P_RESUME] = 1'b1;
            end else begin
                r = go_reset(s);
            end
        end else if (d == D_SUSP) begin
            r = s;
        end else if (u0 && d == D_KEY_A) begin
            r.cyc = 4'(s.cyc + 4'd1);
        end else begin
            r = go_reset(s);
        end
        return r;
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.pulse = '0;
        addr_d     = addr_q;
        data_d     = data_q;

        if (erase_finished && (st_d.mode == MODE_CHIP || st_d.mode == MODE_SECTOR)) begin
            st_d = go_rest(st_d);
        end

        if (wr_en) begin
            addr_d = wr_addr;
            data_d = wr_data;
            if (wr_data == D_RESET && st_d.mode != MODE_PROGRAM &&
                st_d.mode != MODE_CHIP && st_d.mode != MODE_SECTOR) begin
                if (st_d.cyc == CYC_AQRY) begin
                    st_d.cyc  = CYC_ARG;
                    st_d.mode = MODE_AUTOSEL;
                end else begin
                    st_d = go_reset(st_d);
                end
            end else begin
                unique case (st_d.cyc)
                    CYC_IDLE: st_d = open_write(st_d, wr_data, hit_u0, hit_qry, erase_held);
                    CYC_UNL_B: begin
                        if (hit_u1 && wr_data == D_KEY_B) st_d.cyc = CYC_CMD;
                        else                              st_d = go_reset(st_d);
                    end
                    CYC_CMD: begin
                        if (!st_d.bypass && !hit_u0) begin
                            st_d = go_reset(st_d);
                        end else begin
                            unique case (wr_data)
                                D_BYPASS: begin
                                    st_d.bypass = 1'b1;
                                    st_d.cyc    = CYC_CMD;
                                    st_d.mode   = MODE_READ;
                                end
                                D_ERASE: begin
                                    st_d.mode = MODE_ERASE_SETUP;
                                    st_d.cyc  = CYC_ARG;
                                end
                                D_IDENT: begin
                                    st_d.mode           = MODE_AUTOSEL;
                                    st_d.cyc            = CYC_ARG;
                                    st_d.pulse[P_IDENT] = 1'b1;
                                end
                                D_PROG: begin
                                    st_d.mode = MODE_PROGRAM;
                                    st_d.cyc  = CYC_ARG;
                                end
                                default: st_d = go_reset(st_d);
                            endcase
                        end
                    end
                    CYC_ARG: begin
                        unique case (st_d.mode)
                            MODE_ERASE_SETUP:
                                st_d = open_write(st_d, wr_data, hit_u0, hit_qry, erase_held);
                            MODE_PROGRAM: begin
                                if (!(erase_held && target_held)) st_d.pulse[P_PROG] = 1'b1;
                                st_d = go_rest(st_d);
                            end
                            MODE_AUTOSEL: begin
                                if (st_d.bypass && wr_data == D_EXIT) begin
                                    st_d = go_reset(st_d);
                                end else if (hit_qry && wr_data == D_QUERY) begin
                                    st_d.cyc            = CYC_AQRY;
                                    st_d.mode           = MODE_QUERY;
                                    st_d.pulse[P_QUERY] = 1'b1;
                                end else begin
                                    st_d = go_reset(st_d);
                                end
                            end
                            default: st_d = go_reset(st_d);
                        endcase
                    end
                    CYC_UNL_C: begin
                        if (st_d.mode == MODE_PROGRAM) begin
                            st_d = st_d;
                        end else if (st_d.mode == MODE_ERASE_SETUP && hit_u1 &&
                                     wr_data == D_KEY_B) begin
                            st_d.cyc = CYC_UNL_D;
                        end else begin
                            st_d = go_reset(st_d);
                        end
                    end
                    CYC_UNL_D: begin
                        if (erase_held) begin
                            st_d = go_reset(st_d);
                        end else if (wr_data == D_CHIP && hit_u0) begin
                            st_d.mode          = MODE_CHIP;
                            st_d.cyc           = CYC_BUSY;
                            st_d.pulse[P_CHIP] = 1'b1;
                        end else if (wr_data == D_SECT) begin
                            st_d.mode          = MODE_SECTOR;
                            st_d.cyc           = CYC_BUSY;
                            st_d.pulse[P_SECT] = 1'b1;
                        end else begin
                            st_d = go_reset(st_d);
                        end
                    end
                    CYC_BUSY: begin
                        if (st_d.mode == MODE_CHIP) begin
                            st_d = st_d;
                        end else if (st_d.mode == MODE_SECTOR) begin
                            if (wr_data == D_SUSP) begin
                                st_d.cyc           = CYC_IDLE;
                                st_d.mode          = MODE_READ;
                                st_d.pulse[P_SUSP] = 1'b1;
                            end else if (sector_window_open) begin
                                if (wr_data == D_SECT) st_d.pulse[P_SECT] = 1'b1;
                                else                   st_d = go_reset(st_d);
                            end
                        end else begin
                            st_d = go_reset(st_d);
                        end
                    end
                    default: st_d = go_reset(st_d);
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '{cyc: CYC_IDLE, mode: MODE_READ, bypass: 1'b0, pulse: '0};
            addr_q <= '0;
            data_q <= '0;
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
            data_q <= data_d;
        end
    end

    assign cyc_o    = st_q.cyc;
    assign mode_o   = st_q.mode;
    assign bypass_o = st_q.bypass;
    assign pulse_o  = st_q.pulse;
    assign addr_o   = addr_q;
    assign data_o   = data_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter logic [10:0] UNLOCK0   = 11'h555,
    parameter logic [10:0] UNLOCK1   = 11'h2AA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        bus_width,
    input  logic              erase_finished,
    input  logic              sector_window_open,
    input  logic              erase_held,
    input  logic              target_held,
    output logic [3:0]        cycle,
    output logic [2:0]        mode,
    output logic              fast_path,
    output logic              cmd_program,
    output logic              cmd_chip_erase,
    output logic              cmd_sector_erase,
    output logic              cmd_suspend,
    output logic              cmd_resume,
    output logic              cmd_ident,
    output logic              cmd_query,
    output logic              cmd_reset,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data
);
    localparam int          CMP_W     = 11;
    localparam logic [10:0] QUERY_OFS = 11'h055;

    logic                 hit_u0, hit_u1, hit_qry;
    mode_e                mode_w;
    logic [NUM_PULSE-1:0] pulse_w;

    fcd_addr_match #(
        .ADDR_W   (ADDR_W),
        .CMP_W    (CMP_W),
        .UNLOCK0  (UNLOCK0),
        .UNLOCK1  (UNLOCK1),
        .QUERY_OFS(QUERY_OFS)
    ) u_match (
        .wr_addr  (wr_addr),
        .bus_width(bus_width),
        .hit_u0   (hit_u0),
        .hit_u1   (hit_u1),
        .hit_qry  (hit_qry)
    );

    fcd_seq_core #(.ADDR_W(ADDR_W)) u_core (
        .clk               (clk),
        .rst               (rst),
        .wr_en             (wr_en),
        .wr_addr           (wr_addr),
        .wr_data           (wr_data),
        .hit_u0            (hit_u0),
        .hit_u1            (hit_u1),
        .hit_qry           (hit_qry),
        .erase_finished    (erase_finished),
        .sector_window_open(sector_window_open),
        .erase_held        (erase_held),
        .target_held       (target_held),
        .cyc_o             (cycle),
        .mode_o            (mode_w),
        .bypass_o          (fast_path),
        .pulse_o           (pulse_w),
        .addr_o            (cmd_addr),
        .data_o            (cmd_data)
    );

    assign mode             = mode_w;
    assign cmd_program      = pulse_w[P_PROG];
    assign cmd_chip_erase   = pulse_w[P_CHIP];
    assign cmd_sector_erase = pulse_w[P_SECT];
    assign cmd_suspend      = pulse_w[P_SUSP];
    assign cmd_resume       = pulse_w[P_RESUME];
    assign cmd_ident        = pulse_w[P_IDENT];
    assign cmd_query        = pulse_w[P_QUERY];
    assign cmd_reset        = pulse_w[P_RESET];
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
    import fcd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       erase_finished,
    input logic       erase_held,
    input logic [3:0] cycle,
    input logic [2:0] mode,
    input logic       fast_path,
    input logic       cmd_program,
    input logic       cmd_chip_erase,
    input logic       cmd_sector_erase,
    input logic       cmd_suspend,
    input logic       cmd_resume,
    input logic       cmd_ident,
    input logic       cmd_query,
    input logic       cmd_reset
);
    logic [7:0] pulses;
    assign pulses = {cmd_program, cmd_chip_erase, cmd_sector_erase, cmd_suspend,
                     cmd_resume, cmd_ident, cmd_query, cmd_reset};

    a_r1_cycle_range: assert property (@(posedge clk) disable iff (rst)
        cycle <= 4'd8);

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulses));

    a_r4_prog_origin: assert property (@(posedge clk) disable iff (rst)
        cmd_program |-> ($past(wr_en) && $past(cycle) == 4'd3 &&
                         $past(mode) == 3'(MODE_PROGRAM)));

    a_r5_fast_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(fast_path) |-> ($past(wr_data) == 8'h20 && $past(cycle) == 4'd2 &&
                              cycle == 4'd2));

    a_r6_chip_state: assert property (@(posedge clk) disable iff (rst)
        cmd_chip_erase |-> (mode == 3'(MODE_CHIP) && cycle == 4'd6));

    a_r7_query_state: assert property (@(posedge clk) disable iff (rst)
        cmd_query |-> (mode == 3'(MODE_QUERY) && (cycle == 4'd7 || cycle == 4'd8)));

    a_r8_chip_holds: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'(MODE_CHIP) && !erase_finished) |=> mode == 3'(MODE_CHIP));

    a_r9_resume_needs_hold: assert property (@(posedge clk) disable iff (rst)
        cmd_resume |-> ($past(erase_held) && mode == 3'(MODE_SECTOR)));

    a_r10_suspend_origin: assert property (@(posedge clk) disable iff (rst)
        cmd_suspend |-> ($past(mode) == 3'(MODE_SECTOR) && $past(wr_data) == 8'hB0 &&
                         cycle == 4'd0));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .wr_en           (wr_en),
    .wr_data         (wr_data),
    .erase_finished  (erase_finished),
    .erase_held      (erase_held),
    .cycle           (cycle),
    .mode            (mode),
    .fast_path       (fast_path),
    .cmd_program     (cmd_program),
    .cmd_chip_erase  (cmd_chip_erase),
    .cmd_sector_erase(cmd_sector_erase),
    .cmd_suspend     (cmd_suspend),
    .cmd_resume      (cmd_resume),
    .cmd_ident       (cmd_ident),
    .cmd_query       (cmd_query),
    .cmd_reset       (cmd_reset)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;
    localparam int AW = 24;
    localparam int U0 = 'h555;
    localparam int U1 = 'h2AA;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [1:0]    bus_width = 2'd0;
    logic          erase_finished = 1'b0;
    logic          sector_window_open = 1'b0;
    logic          erase_held = 1'b0;
    logic          target_held = 1'b0;
    logic [3:0]    cycle;
    logic [2:0]    mode;
    logic          fast_path;
    logic          cmd_program, cmd_chip_erase, cmd_sector_erase, cmd_suspend;
    logic          cmd_resume, cmd_ident, cmd_query, cmd_reset;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    cmd_data;

    flash_cmd_decoder #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bus_width(bus_width), .erase_finished(erase_finished),
        .sector_window_open(sector_window_open), .erase_held(erase_held),
        .target_held(target_held), .cycle(cycle), .mode(mode), .fast_path(fast_path),
        .cmd_program(cmd_program), .cmd_chip_erase(cmd_chip_erase),
        .cmd_sector_erase(cmd_sector_erase), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_ident(cmd_ident), .cmd_query(cmd_query),
        .cmd_reset(cmd_reset), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    always #10 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pulses();
        return {cmd_program, cmd_chip_erase, cmd_sector_erase, cmd_suspend,
                cmd_resume, cmd_ident, cmd_query, cmd_reset};
    endfunction

    // ---------------- behavioural reference model ----------------
    int       m_cycle = 0;
    int       m_mode  = 0;
    bit       m_fast  = 0;
    bit [7:0] m_pv    = 0;

    function automatic int fold(input int a, input int bw);
        int sh = (bw == 0) ? 0 : (bw == 1) ? 1 : 2;
        return (a >> sh) & 'h7FF;
    endfunction

    task m_abort();
        m_cycle = 0; m_mode = 0; m_fast = 0; m_pv[0] = 1'b1;
    endtask

    task m_settle();
        m_cycle = m_fast ? 2 : 0; m_mode = 0;
    endtask

    task m_opener(input int d, input int a);
        if (a == 'h55 && d == 'h98) begin
            m_cycle = 7; m_mode = 2; m_pv[1] = 1'b1;
        end else if (d == 'h30) begin
            if (erase_held) begin m_cycle = 6; m_mode = 6; m_pv[3] = 1'b1; end
            else m_abort();
        end else if (d == 'hB0) begin
        end else if (a == U0 && d == 'hAA) begin
            m_cycle = m_cycle + 1;
        end else m_abort();
    endtask

    task m_write(input int d, input int a);
        if (d == 'hF0 && !(m_mode == 3 || m_mode == 5 || m_mode == 6)) begin
            if (m_cycle == 8) begin m_cycle = 3; m_mode = 1; end
            else m_abort();
        end else if (m_cycle == 0) begin
            m_opener(d, a);
        end else if (m_cycle == 1) begin
            if (a == U1 && d == 'h55) m_cycle = 2; else m_abort();
        end else if (m_cycle == 2) begin
            if (!m_fast && a != U0) m_abort();
            else if (d == 'h20) begin m_fast = 1; m_cycle = 2; m_mode = 0; end
            else if (d == 'h80) begin m_mode = 4; m_cycle = 3; end
            else if (d == 'h90) begin m_mode = 1; m_cycle = 3; m_pv[2] = 1'b1; end
            else if (d == 'hA0) begin m_mode = 3; m_cycle = 3; end
            else m_abort();
        end else if (m_cycle == 3) begin
            if (m_mode == 4) m_opener(d, a);
            else if (m_mode == 3) begin
                if (!(erase_held && target_held)) m_pv[7] = 1'b1;
                m_settle();
            end else if (m_mode == 1) begin
                if (m_fast && d == 0) m_abort();
                else if (a == 'h55 && d == 'h98) begin m_cycle = 8; m_mode = 2; m_pv[1] = 1'b1; end
                else m_abort();
            end else m_abort();
        end else if (m_cycle == 4) begin
            if (m_mode == 3) begin end
            else if (m_mode == 4 && a == U1 && d == 'h55) m_cycle = 5;
            else m_abort();
        end else if (m_cycle == 5) begin
            if (erase_held) m_abort();
            else if (d == 'h10 && a == U0) begin m_mode = 5; m_cycle = 6; m_pv[6] = 1'b1; end
            else if (d == 'h30) begin m_mode = 6; m_cycle = 6; m_pv[5] = 1'b1; end
            else m_abort();
        end else if (m_cycle == 6) begin
            if (m_mode == 5) begin end
            else if (m_mode == 6) begin
                if (d == 'hB0) begin m_cycle = 0; m_mode = 0; m_pv[4] = 1'b1; end
                else if (sector_window_open) begin
                    if (d == 'h30) m_pv[5] = 1'b1; else m_abort();
                end
            end else m_abort();
        end else m_abort();
    endtask

    always @(posedge clk) begin
        m_pv = 0;
        if (rst) begin
            m_cycle = 0; m_mode = 0; m_fast = 0;
        end else begin
            if (erase_finished && (m_mode == 5 || m_mode == 6)) m_settle();
            if (wr_en) m_write(wr_data, fold(wr_addr, bus_width));
        end
    end

    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            chk("R1", "model cycle", cycle, m_cycle);
            chk("R3", "model mode", mode, m_mode);
            chk("R5", "model fast path", fast_path, m_fast);
            chk("R10", "model pulses", pulses(), m_pv);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int a, input int d);
        wr_addr = AW'(a); wr_data = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_fin(input int a, input int d);
        wr_addr = AW'(a); wr_data = 8'(d); wr_en = 1'b1; erase_finished = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; erase_finished = 1'b0;
    endtask

    task automatic finish_erase();
        erase_finished = 1'b1;
        @(negedge clk);
        erase_finished = 1'b0;
    endtask

    task automatic unlock();
        wr(U0, 'hAA); wr(U1, 'h55);
    endtask

    task automatic sector_start(input int a);
        unlock(); wr(U0, 'h80); unlock(); wr(a, 'h30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "reset cycle", cycle, 0);
        chk("R12", "reset mode", mode, 0);
        chk("R12", "reset fast", fast_path, 0);
        rst = 1'b0;
        @(negedge clk);

        wr(U0, 'hAA);  chk("R1", "after key A", cycle, 1);
        wr(U1, 'h55);  chk("R1", "after key B", cycle, 2);
        wr(U0, 'h90);  chk("R3", "ident mode", mode, 1);
        chk("R3", "ident pulse", pulses(), 'h04);
        wr('h55, 'h98); chk("R7", "ident query cycle", cycle, 8);
        chk("R7", "ident query mode", mode, 2);
        wr(0, 'hF0);   chk("R7", "back to ident", {28'd0, cycle} * 16 + mode, 'h31);
        wr(0, 'hF0);   chk("R8", "reset from ident", pulses(), 'h01);
        chk("R8", "idle after F0", cycle, 0);

        wr(U0, 'hAA); wr('h123, 'h55);
        chk("R1", "bad key B", cycle, 0); chk("R1", "bad key B pulse", pulses(), 'h01);

        wr('h55, 'h98); chk("R7", "query from idle", cycle, 7);
        wr('h100, 'h12); chk("R7", "query exit", cycle, 0);

        bus_width = 2'd1;
        wr(U0 * 2, 'hAA); wr(U1 * 2, 'h55); chk("R2", "x16 unlock", cycle, 2);
        wr(0, 'hF0);
        wr(U0, 'hAA);  chk("R2", "x16 unscaled miss", cycle, 0);
        bus_width = 2'd2;
        wr(U0 * 4, 'hAA); wr(U1 * 4, 'h55); chk("R2", "x32 unlock", cycle, 2);
        wr(0, 'hF0);
        bus_width = 2'd0;
        wr('h1555, 'hAA); chk("R2", "upper bits ignored", cycle, 1);
        wr(0, 'hF0);

        unlock(); wr(U0, 'hA0); chk("R3", "program mode", mode, 3);
        wr('h1234, 'hF0);
        chk("R4", "program pulse", pulses(), 'h80);
        chk("R4", "program addr", cmd_addr, 'h1234);
        chk("R4", "program data", cmd_data, 'hF0);
        chk("R4", "program idle", cycle, 0);

        unlock(); wr(U0, 'h20);
        chk("R5", "fast on", fast_path, 1); chk("R5", "fast cycle", cycle, 2);
        wr('h777, 'hA0); chk("R5", "fast program mode", mode, 3);
        wr('h10, 'h5A);  chk("R5", "fast program pulse", pulses(), 'h80);
        chk("R5", "fast return", cycle, 2);
        wr('h3, 'h90);   chk("R5", "fast ident", mode, 1);
        wr('h3, 'h00);   chk("R5", "fast exit", fast_path, 0);
        chk("R5", "fast exit pulse", pulses(), 'h01);

        unlock(); wr(U0, 'h80); chk("R6", "erase setup", mode, 4);
        unlock(); wr(U0, 'h10);
        chk("R6", "chip pulse", pulses(), 'h40); chk("R6", "chip mode", mode, 5);
        wr(0, 'hF0); chk("R8", "F0 ignored in chip", mode, 5);
        chk("R8", "no reset pulse", pulses(), 'h00);
        finish_erase(); chk("R11", "chip done", mode, 0);
        unlock(); wr(U0, 'h80); unlock(); wr('h123, 'h10);
        chk("R6", "chip wrong addr", pulses(), 'h01);

        sector_window_open = 1'b1;
        sector_start('h4000);
        chk("R6", "sector pulse", pulses(), 'h20); chk("R6", "sector addr", cmd_addr, 'h4000);
        wr('h8000, 'h30); chk("R10", "second sector", pulses(), 'h20);
        sector_window_open = 1'b0;
        wr('h8000, 'h55); chk("R10", "ignored after window", mode, 6);
        wr(0, 'hB0); chk("R10", "suspend pulse", pulses(), 'h10);
        chk("R10", "suspend idle", mode, 0);

        erase_held = 1'b1; target_held = 1'b1;
        wr(0, 'hB0); chk("R9", "B0 at idle", pulses(), 'h00);
        unlock(); wr(U0, 'hA0); wr('h200, 'h00);
        chk("R4", "held program dropped", pulses(), 'h00); chk("R4", "held program idle", cycle, 0);
        target_held = 1'b0;
        unlock(); wr(U0, 'hA0); wr('h200, 'h00); chk("R4", "other sector program", pulses(), 'h80);
        sector_start('h4000); chk("R6", "erase refused while held", pulses(), 'h01);
        wr(0, 'h30); chk("R9", "resume pulse", pulses(), 'h08);
        chk("R9", "resume mode", mode, 6);
        erase_held = 1'b0;
        finish_erase();
        wr(0, 'h30); chk("R9", "30 without hold", pulses(), 'h01);

        sector_window_open = 1'b1;
        sector_start('h4000); wr(0, 'h77);
        chk("R10", "window other data", pulses(), 'h01);
        sector_window_open = 1'b0;

        sector_start('h4000);
        wr_fin(U0, 'hAA); chk("R11", "write with done", cycle, 1);
        chk("R11", "write with done mode", mode, 0);
        wr(0, 'hF0);

        unlock(); wr(U0, 'h20); wr(0, 'h80); unlock(); wr('h9000, 'h30);
        chk("R11", "fast sector", pulses(), 'h20);
        wr_fin('h7, 'hA0); chk("R11", "fast done then cmd", mode, 3);
        wr('h8, 'h33); chk("R11", "fast kept", fast_path, 1);
        wr(0, 'hF0); chk("R8", "fast cleared by F0", fast_path, 0);

        unlock();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R12", "mid reset cycle", cycle, 0);
        chk("R12", "mid reset pulses", pulses(), 'h00);
        @(negedge clk);

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule